// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end of a byte-wide flash array. It watches bus write cycles and decodes multi-write unlock sequences. Each step of a sequence is keyed on both the data byte and the low twelve address bits. From these sequences it starts byte programming, whole-array erase and per-sector erase. While an erase is running it also accepts suspend and resume commands. Writes that do not complete a valid sequence never reach the array.

While an operation runs, the block reports progress in two ways. Reads return a status byte instead of array data: bit 7 is the complement of the bit-7 value being written, and bit 6 flips on every read. A ready output is also low. The array is an internal byte memory. The length of each operation is set by parameter-driven cycle counters.

A sector-erase command opens an append window. Each further erase-confirm write within that window adds another sector to the same erase and restarts the window. When the window expires, the timed erase phase runs. A sweep then writes FFh to every byte whose sector is selected. A suspend during the timed phase freezes it and makes the array readable, and a resume continues from the same count.

Top module: `flash_cmd_seq`

## Requirements
- R1: A bus write that does not complete a valid sequence leaves the array unchanged. A byte or address that does not match the expected step sends the decoder back to read mode. This includes F0h written at any step.
- R2: Programming uses four writes: AAh at low address 555h, 55h at AAAh, A0h at 555h, then the data byte at the target address. The target byte becomes its old value ANDed with the data, so bits only ever go from 1 to 0.
- R3: After a program command, `rdy` stays low for exactly PROG_CYC consecutive cycles and then returns high.
- R4: A read made while `rdy` is low returns a status byte. Bit 7 is the complement of the target bit 7, where an erase counts as a target of FFh. Bit 6 flips on each such read. Bits 5..0 are zero.
- R5: The erase prefix is AAh@555h, 55h@AAAh, 80h@555h, AAh@555h, 55h@AAAh. Following it with 10h at 555h erases every byte to FFh, with `rdy` low for ERASE_CYC + DEPTH cycles.
- R6: Following the erase prefix with 30h at any address erases the sector holding that address, which is address bits [ADDR_W-1 -: SECT_W]. Other sectors are left untouched, and `rdy` is low for WIN_CYC + ERASE_CYC + DEPTH cycles.
- R7: A 30h write during the append window adds the addressed sector to the pending erase and restarts the window.
- R8: During the timed erase phase, every write other than the suspend byte B0h is ignored, including complete program sequences.
- R9: B0h during the timed erase phase suspends the erase. `rdy` goes high and reads return array data from any sector. A later 30h write resumes the erase, which then completes normally.
- R10: A pulse on `abort_rst` stops any running operation in the next cycle. `rdy` returns high, and the target of an aborted program keeps its old value.
- R11: A pulse on `soft_rst` clears a partly entered sequence but lets a running program complete.
- R12: While `secure` or `vlow` is high, all bus writes are ignored.
- R13: After `rst`, `rdy` is high and the decoder is in read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| abort_rst | input | 1 | Warm reset; aborts a running operation |
| soft_rst | input | 1 | Clears partial sequence decode only |
| secure | input | 1 | Device secured; writes refused |
| vlow | input | 1 | Supply-low lockout; writes refused |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | BUS_AW | Bus address |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Read data or status, valid the cycle after `rd_en` |
| rdy | output | 1 | High when no operation is busy |

## Verification
The bench builds the block with ADDR_W=8 (four 64-byte sectors), PROG_CYC=6, ERASE_CYC=10 and WIN_CYC=12. With these values a full erase sweep takes only 256 cycles, so the exact busy length of every operation can be counted. The erase phases are also short enough that appends, suspend timing and writes ignored mid-erase can be placed on chosen cycles. A whole-array readback can then follow every erase.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  localparam logic [7:0]  K_UNL1 = 8'hAA;
  localparam logic [7:0]  K_UNL2 = 8'h55;
  localparam logic [7:0]  K_PROG = 8'hA0;
  localparam logic [7:0]  K_ERS  = 8'h80;
  localparam logic [7:0]  K_CHIP = 8'h10;
  localparam logic [7:0]  K_SECT = 8'h30;
  localparam logic [7:0]  K_SUSP = 8'hB0;
  localparam logic [11:0] ADR_A  = 12'h555;
  localparam logic [11:0] ADR_B  = 12'hAAA;

  typedef enum logic [2:0] {
    E_IDLE, E_PROG, E_WIN, E_ERASE, E_SUSP, E_SWEEP
  } eng_st_t;

  typedef enum logic [2:0] {
    D_READ, D_U1, D_U2, D_PDATA, D_E3, D_E4, D_E5
  } dec_st_t;

  typedef struct packed {
    logic prog;
    logic chip;
    logic sect;
    logic append;
    logic susp;
    logic resume;
  } cmd_t;

endpackage

// File: rtl/fcs_decode.sv
module fcs_decode
  import fcs_pkg::*;
#(
  parameter int BUS_AW = 12,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              lock,
  input  logic              wr_en,
  input  logic [BUS_AW-1:0] addr,
  input  logic [7:0]        wdata,
  input  eng_st_t           eng_st,
  output cmd_t              cmd,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data
);

  dec_st_t st;
  logic    hit_a, hit_b;
  logic [5:0] cmd_v;

  assign hit_a = (addr[11:0] == ADR_A);
  assign hit_b = (addr[11:0] == ADR_B);
  assign cmd_v = cmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= D_READ;
      cmd      <= '0;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else begin
      cmd <= '0;
      if (soft_rst) begin
        st <= D_READ;
      end else if (wr_en && !lock) begin
        cmd_addr <= addr[ADDR_W-1:0];
        cmd_data <= wdata;
        if (eng_st == E_IDLE) begin
          st <= D_READ;
          unique case (st)
            D_READ:  if (wdata == K_UNL1 && hit_a) st <= D_U1;
            D_U1:    if (wdata == K_UNL2 && hit_b) st <= D_U2;
            D_U2: begin
              if (wdata == K_PROG && hit_a) st <= D_PDATA;
              else if (wdata == K_ERS && hit_a) st <= D_E3;
            end
            D_PDATA: cmd.prog <= 1'b1;
            D_E3:    if (wdata == K_UNL1 && hit_a) st <= D_E4;
            D_E4:    if (wdata == K_UNL2 && hit_b) st <= D_E5;
            D_E5: begin
              if (wdata == K_CHIP && hit_a) cmd.chip <= 1'b1;
              else if (wdata == K_SECT) cmd.sect <= 1'b1;
            end
            default: st <= D_READ;
          endcase
        end else begin
          st <= D_READ;
          if (eng_st == E_WIN && wdata == K_SECT) cmd.append <= 1'b1;
          if (eng_st == E_ERASE && wdata == K_SUSP) cmd.susp <= 1'b1;
          if (eng_st == E_SUSP && wdata == K_SECT) cmd.resume <= 1'b1;
        end
      end
    end
  end

  a_r1_cmd_needs_write: assert property (@(posedge clk) disable iff (rst)
    (|cmd_v) |-> $past(wr_en));
  a_r12_locked_no_cmd: assert property (@(posedge clk) disable iff (rst)
    (|cmd_v) |-> !$past(lock));
  a_r1_single_cmd: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_v));

endmodule

// File: rtl/fcs_array.sv
module fcs_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        q
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end

endmodule

// File: rtl/fcs_engine.sv
module fcs_engine
  import fcs_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int SECT_W    = 3,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 64,
  parameter int WIN_CYC   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  cmd_t              cmd,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic [7:0]        arr_q,
  output eng_st_t           st,
  output logic              busy,
  output logic              tgt7,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W-1:0] rdaddr,
  output logic [7:0]        wdata
);

  localparam int NSEC  = 1 << SECT_W;
  localparam int M1    = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int MAXC  = (M1 > WIN_CYC) ? M1 : WIN_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] PROG_LD = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] ERS_LD  = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] WIN_LD  = CNT_W'(WIN_CYC - 1);

  logic [CNT_W-1:0]  cnt;
  logic [NSEC-1:0]   mask;
  logic [ADDR_W-1:0] tgt_a, ptr;
  logic [7:0]        tgt_d;
  logic [SECT_W-1:0] ptr_sec;

  function automatic logic [NSEC-1:0] sec_bit(input logic [ADDR_W-1:0] a);
    logic [NSEC-1:0] v;
    v = '0;
    v[a[ADDR_W-1 -: SECT_W]] = 1'b1;
    return v;
  endfunction

  assign ptr_sec = ptr[ADDR_W-1 -: SECT_W];
  assign busy    = (st == E_PROG) || (st == E_WIN) || (st == E_ERASE) || (st == E_SWEEP);
  assign tgt7    = (st == E_PROG) ? tgt_d[7] : 1'b1;
  assign we      = ((st == E_PROG) && (cnt == '0)) || ((st == E_SWEEP) && mask[ptr_sec]);
  assign waddr   = (st == E_PROG) ? tgt_a : ptr;
  assign wdata   = (st == E_PROG) ? (arr_q & tgt_d) : 8'hFF;
  assign rdaddr  = tgt_a;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      st    <= E_IDLE;
      cnt   <= '0;
      mask  <= '0;
      tgt_a <= '0;
      tgt_d <= '0;
      ptr   <= '0;
    end else begin
      unique case (st)
        E_IDLE: begin
          if (cmd.prog) begin
            tgt_a <= cmd_addr;
            tgt_d <= cmd_data;
            cnt   <= PROG_LD;
            st    <= E_PROG;
          end else if (cmd.chip) begin
            mask <= '1;
            cnt  <= ERS_LD;
            st   <= E_ERASE;
          end else if (cmd.sect) begin
            mask <= sec_bit(cmd_addr);
            cnt  <= WIN_LD;
            st   <= E_WIN;
          end
        end
        E_PROG: begin
          if (cnt == '0) st <= E_IDLE;
          else cnt <= cnt - 1'b1;
        end
        E_WIN: begin
          if (cmd.append) begin
            mask <= mask | sec_bit(cmd_addr);
            cnt  <= WIN_LD;
          end else if (cnt == '0) begin
            cnt <= ERS_LD;
            st  <= E_ERASE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        E_ERASE: begin
          if (cmd.susp) st <= E_SUSP;
          else if (cnt == '0) begin
            ptr <= '0;
            st  <= E_SWEEP;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        E_SUSP: if (cmd.resume) st <= E_ERASE;
        E_SWEEP: begin
          if (ptr == {ADDR_W{1'b1}}) begin
            mask <= '0;
            st   <= E_IDLE;
          end else begin
            ptr <= ptr + 1'b1;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  a_r3_prog_from_idle: assert property (@(posedge clk) disable iff (rst)
    (st == E_PROG && $past(st) != E_PROG) |-> $past(st) == E_IDLE);
  a_r9_susp_from_erase: assert property (@(posedge clk) disable iff (rst)
    (st == E_SUSP && $past(st) != E_SUSP) |-> ($past(st) == E_ERASE && $past(cmd.susp)));
  a_r6_mask_while_erasing: assert property (@(posedge clk) disable iff (rst)
    (st == E_WIN || st == E_ERASE || st == E_SUSP || st == E_SWEEP) |-> (mask != '0));
  a_r10_abort_to_idle: assert property (@(posedge clk) disable iff (rst)
    abort |=> (st == E_IDLE));
  a_r8_write_only_when_active: assert property (@(posedge clk) disable iff (rst)
    we |-> (st == E_PROG || st == E_SWEEP));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int BUS_AW    = 12,
  parameter int ADDR_W    = 11,
  parameter int SECT_W    = 3,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 64,
  parameter int WIN_CYC   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort_rst,
  input  logic              soft_rst,
  input  logic              secure,
  input  logic              vlow,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BUS_AW-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rdy
);

  cmd_t              cmd;
  eng_st_t           eng_st;
  logic [ADDR_W-1:0] cmd_addr, waddr, eng_raddr, raddr;
  logic [7:0]        cmd_data, arr_q, arr_wd, status_q;
  logic              busy, tgt7, arr_we, busy_rd_q, tog_q;

  fcs_decode #(.BUS_AW(BUS_AW), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .lock(secure | vlow),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .eng_st(eng_st),
    .cmd(cmd), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  fcs_engine #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYC(PROG_CYC),
    .ERASE_CYC(ERASE_CYC), .WIN_CYC(WIN_CYC)
  ) u_eng (
    .clk(clk), .rst(rst), .abort(abort_rst), .cmd(cmd), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .arr_q(arr_q), .st(eng_st), .busy(busy), .tgt7(tgt7),
    .we(arr_we), .waddr(waddr), .rdaddr(eng_raddr), .wdata(arr_wd)
  );

  assign raddr = busy ? eng_raddr : addr[ADDR_W-1:0];

  fcs_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .we(arr_we), .waddr(waddr), .wdata(arr_wd), .raddr(raddr), .q(arr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_rd_q <= 1'b0;
      status_q  <= '0;
      tog_q     <= 1'b0;
    end else if (rd_en) begin
      busy_rd_q <= busy;
      if (busy) begin
        status_q <= {~tgt7, tog_q, 6'b0};
        tog_q    <= ~tog_q;
      end
    end
  end

  assign rdata = busy_rd_q ? status_q : arr_q;
  assign rdy   = ~busy;

  a_r4_dq6_flips: assert property (@(posedge clk) disable iff (rst)
    (rd_en && busy && $past(rd_en && busy)) |=> (rdata[6] != $past(rdata[6])));
  a_r4_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && busy) |=> (rdata[5:0] == 6'b0));

endmodule

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;

  localparam int AW = 8, SW = 2, PC = 6, EC = 10, WC = 12;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, abort_rst, soft_rst, secure, vlow, wr_en, rd_en, rdy;
  logic [11:0] addr;
  logic [7:0]  wdata, rdata;

  flash_cmd_seq #(.BUS_AW(12), .ADDR_W(AW), .SECT_W(SW), .PROG_CYC(PC),
                  .ERASE_CYC(EC), .WIN_CYC(WC)) dut (
    .clk(clk), .rst(rst), .abort_rst(abort_rst), .soft_rst(soft_rst),
    .secure(secure), .vlow(vlow), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdy(rdy)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] model [DEPTH];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    @(negedge clk);
    while (!rdy && n < 20000) begin n++; @(negedge clk); end
  endtask

  task automatic prog_cmd(input logic [7:0] a, input logic [7:0] d);
    wr(12'h555, 8'hAA); wr(12'hAAA, 8'h55); wr(12'h555, 8'hA0); wr({4'h0, a}, d);
  endtask

  task automatic erase_prefix();
    wr(12'h555, 8'hAA); wr(12'hAAA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'hAAA, 8'h55);
  endtask

  function automatic logic [7:0] prog_val(input logic [7:0] old, input logic [7:0] d);
    return old & d;
  endfunction

  task automatic erase_model(input int s);
    for (int i = 0; i < DEPTH; i++) if ((i >> (AW - SW)) == s) model[i] = 8'hFF;
  endtask

  task automatic verify_all(input string req);
    logic [7:0] r;
    int bad = 0, ba = 0, bv = 0;
    for (int i = 0; i < DEPTH; i++) begin
      rd(12'(i), r);
      if (r !== model[i]) begin
        if (bad == 0) begin ba = i; bv = r; end
        bad++;
      end
    end
    check(bad == 0, req, bv, model[ba]);
  endtask

  task automatic read_chk(input logic [7:0] a, input string req);
    logic [7:0] r;
    rd({4'h0, a}, r);
    check(r === model[a], req, r, model[a]);
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_up();
    end
  end

  initial begin
    int n;
    logic [7:0] r1, r2, a, d;
    void'($urandom(32'd2024));
    rst = 1; abort_rst = 0; soft_rst = 0; secure = 0; vlow = 0;
    wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    idle(4); rst = 0; idle(1);
    check(rdy === 1'b1, "R13 rdy after reset", rdy, 1);

    // R5 chip erase
    erase_prefix(); wr(12'h555, 8'h10);
    busy_len(n);
    check(n == EC + DEPTH, "R5 chip erase busy", n, EC + DEPTH);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    verify_all("R5 chip erase data");

    // R2/R3 directed program, one per sector
    for (int s = 0; s < 4; s++) begin
      a = 8'(s * 64 + 5);
      prog_cmd(a, 8'h3C);
      busy_len(n);
      check(n == PC, "R3 program busy", n, PC);
      model[a] = prog_val(model[a], 8'h3C);
      read_chk(a, "R2 program data");
    end
    // R2 bits only cleared
    prog_cmd(8'h05, 8'hF0); busy_len(n);
    model[8'h05] = prog_val(model[8'h05], 8'hF0);
    read_chk(8'h05, "R2 and of old and new");

    // random programs with status reads
    for (int i = 0; i < 16; i++) begin
      a = 8'($urandom % DEPTH); d = 8'($urandom);
      prog_cmd(a, d);
      if (i % 2 == 1) begin
        rd({4'h0, a}, r1); rd({4'h0, a}, r2);
        check(r1[7] == ~d[7] && r1[5:0] == 6'd0, "R4 program status", r1, {~d[7], r1[6], 6'd0});
        check(r2[6] != r1[6], "R4 DQ6 toggle", r2, {r2[7], ~r1[6], r2[5:0]});
        busy_len(n);
      end else begin
        busy_len(n);
        check(n == PC, "R3 program busy random", n, PC);
      end
      model[a] = prog_val(model[a], d);
      read_chk(a, "R2 random program");
    end

    // R1 plain write, wrong byte, wrong address, F0 mid-sequence
    wr(12'h011, 8'h00); read_chk(8'h11, "R1 plain write ignored");
    wr(12'h555, 8'hAA); wr(12'hAAA, 8'h55); wr(12'h555, 8'h12); wr(12'h022, 8'h00);
    check(rdy === 1'b1, "R1 wrong byte no op", rdy, 1);
    read_chk(8'h22, "R1 wrong byte");
    wr(12'h555, 8'hAA); wr(12'h555, 8'h55); wr(12'h555, 8'hA0); wr(12'h023, 8'h00);
    read_chk(8'h23, "R1 wrong address");
    wr(12'h555, 8'hAA); wr(12'h000, 8'hF0); wr(12'hAAA, 8'h55); wr(12'h555, 8'hA0);
    wr(12'h033, 8'h00);
    read_chk(8'h33, "R1 F0 mid sequence");

    // R12 lock inputs
    secure = 1; prog_cmd(8'h44, 8'h00); idle(2);
    check(rdy === 1'b1, "R12 secure blocks", rdy, 1);
    read_chk(8'h44, "R12 secure data");
    secure = 0; vlow = 1; prog_cmd(8'h45, 8'h00); idle(2);
    check(rdy === 1'b1, "R12 vlow blocks", rdy, 1);
    read_chk(8'h45, "R12 vlow data");
    vlow = 0;

    // R11 soft reset
    wr(12'h555, 8'hAA); wr(12'hAAA, 8'h55);
    @(negedge clk); soft_rst = 1; @(negedge clk); soft_rst = 0;
    wr(12'h555, 8'hA0); wr(12'h050, 8'h00);
    read_chk(8'h50, "R11 partial sequence cleared");
    prog_cmd(8'h51, 8'h0F);
    @(negedge clk); soft_rst = 1; @(negedge clk); soft_rst = 0;
    busy_len(n);
    model[8'h51] = prog_val(model[8'h51], 8'h0F);
    read_chk(8'h51, "R11 program survives soft reset");

    // R10 warm abort
    prog_cmd(8'h52, 8'h00); idle(2);
    @(negedge clk); abort_rst = 1; @(negedge clk); abort_rst = 0;
    check(rdy === 1'b1, "R10 abort rdy", rdy, 1);
    read_chk(8'h52, "R10 aborted target unchanged");

    // R6 single sector erase (sector 2)
    erase_prefix(); wr(12'h083, 8'h30);
    busy_len(n);
    check(n == WC + EC + DEPTH, "R6 sector erase busy", n, WC + EC + DEPTH);
    erase_model(2);
    verify_all("R6 sector erase data");

    // R7 append sector 3 to sector 1
    erase_prefix(); wr(12'h040, 8'h30); idle(3); wr(12'h0C0, 8'h30);
    busy_len(n);
    erase_model(1); erase_model(3);
    verify_all("R7 appended sectors erased");

    // R8 program during erase ignored, R4 erase status
    erase_prefix(); wr(12'h007, 8'h30);
    rd(12'h007, r1); rd(12'h007, r2);
    check(r1[7] == 1'b0 && r1[5:0] == 6'd0, "R4 erase status", r1, {1'b0, r1[6], 6'd0});
    check(r2[6] != r1[6], "R4 erase DQ6 toggle", r2, {r2[7], ~r1[6], r2[5:0]});
    idle(10);
    prog_cmd(8'h90, 8'h00);
    busy_len(n);
    erase_model(0);
    read_chk(8'h90, "R8 program during erase ignored");
    read_chk(8'h07, "R8 erase still completes");

    // R9 suspend / resume on sector 0
    prog_cmd(8'h07, 8'h5A); busy_len(n);
    model[8'h07] = prog_val(model[8'h07], 8'h5A);
    erase_prefix(); wr(12'h007, 8'h30); idle(WC + 2);
    wr(12'h000, 8'hB0); idle(1);
    check(rdy === 1'b1, "R9 suspended rdy", rdy, 1);
    read_chk(8'h07, "R9 suspended sector readable");
    read_chk(8'h90, "R9 other sector readable");
    wr(12'h000, 8'h30);
    busy_len(n);
    check(n > 0, "R9 resume busy", n, 1);
    erase_model(0);
    read_chk(8'h07, "R9 erase completes after resume");

    verify_all("R2 final array");
    done = 1;
    finish_up();
  end

endmodule